// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block collects two banks of level-sensitive interrupt requests: a wide bank of 64 lines from peripherals and a narrow bank of 8 lines from the local core. It produces one normal interrupt request and one fast interrupt request for the processor. Each bank has an enable mask. The normal request is raised while any source is both active and enabled. The fast request tracks one chosen source directly, and the enable masks do not affect it.

Software reaches the block through a simple word-wide port with valid, write, address and data signals. Each bank has one register that sets enable bits and another that clears them, so single bits can be changed without a read-modify-write. Three read-only views show the pending state. Two of them are the masked peripheral lines, split into low and high halves. The third is a summary word. It carries the masked local lines, one flag for each peripheral half, and direct copies of eleven frequently used peripheral lines, so a handler can often decide what to do from one read.

Every source is sampled into a register once per clock. Enables and fast-request routing change on the clock edge that ends a write. The outputs and all read data come combinationally from this registered state.

Top module: `banked_intc`

## Requirements
- R1: Reset clears both enable masks, the fast-request enable and its 7-bit source select. After reset, irq_o and fiq_o stay low whatever the source levels are.
- R2: A write to byte offset 0x10 (peripheral lines 31:0), 0x14 (lines 63:32) or 0x18 (local lines, data bits 7:0) sets each enable bit whose data bit is 1 and leaves all other enable bits unchanged. Reading the same offset returns the mask, zero-extended to 32 bits.
- R3: A write to byte offset 0x1C, 0x20 or 0x24 clears each enable bit of the matching group (peripheral low half, peripheral high half, local) whose data bit is 1. Reading one of these offsets returns the bitwise inverse of the full 32-bit zero-extended mask.
- R4: Offset 0x04 reads the sampled levels of peripheral lines 31:0 ANDed with their enables. Offset 0x08 gives the same for lines 63:32.
- R5: In the summary word at offset 0x00, bits 7:0 are the sampled local levels ANDed with the local enables. Bit 8 is set when any enabled peripheral line in 31:0 is active. Bit 9 is set when any enabled peripheral line in 63:32 is active.
- R6: Summary bits 10 through 20 copy the enabled pending state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order, one bit each. Bits 31:21 read as zero.
- R7: irq_o is high exactly when at least one sampled source in either bank is active and enabled.
- R8: At offset 0x0C, bit 7 enables the fast request and bits 6:0 select its source. Higher data bits are dropped, and a read returns {24'b0, enable, select}. When enabled with select 0 to 63, fiq_o follows the sampled level of that peripheral line, whatever the enable masks hold.
- R9: Select values 64 to 71 route local line (select − 64) to fiq_o. Select values 72 to 127 drive fiq_o low. When the fast request is disabled, fiq_o is low.
- R10: A read of any offset other than the ten mapped word offsets returns zero. A write to an unmapped offset, or to 0x00, 0x04 or 0x08, changes no state.
- R11: A source change becomes visible in read data and in the outputs one clock edge later. In the cycle in which an input changes, reads still return the previous sampled value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| periph_irq_i | input | 64 | Peripheral interrupt levels, active high |
| local_irq_i | input | 8 | Local core interrupt levels, active high |
| bus_valid_i | input | 1 | Access request for this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address within the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle; zero when no read is requested |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is a line that is raised but masked while it still drives fiq_o. In that case the bench must see the fast request high and irq_o low in the same cycle. To get there, the bench first clears every enable through all three clear-enable registers. It then routes a single peripheral line, and later a single local line, to the fast request and shows that fiq_o follows each raw level. The duplicate bits in the summary word are tested by raising both duplicated and non-duplicated lines in each half. The bench then masks one duplicated line in the high half while another line in that half stays enabled, so the half's summary flag stays set and only the mirror bit for the masked line drops.

// File: rtl/banked_intc_pkg.sv
package banked_intc_pkg;

    localparam int unsigned N_PERIPH = 64;
    localparam int unsigned N_LOCAL  = 8;
    localparam int unsigned HALF_W   = N_PERIPH / 2;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned SEL_W    = 7;
    localparam int unsigned N_MIRROR = 11;
    localparam int unsigned MIRROR_LSB = N_LOCAL + 2;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_SUMMARY,
        REG_PEND_LO,
        REG_PEND_HI,
        REG_FASTCTL,
        REG_SET_LO,
        REG_SET_HI,
        REG_SET_LOC,
        REG_CLR_LO,
        REG_CLR_HI,
        REG_CLR_LOC
    } reg_sel_e;

    typedef struct packed {
        logic [N_PERIPH-1:0] lvl_p;
        logic [N_LOCAL-1:0]  lvl_l;
        logic [N_PERIPH-1:0] en_p;
        logic [N_LOCAL-1:0]  en_l;
        logic                fast_en;
        logic [SEL_W-1:0]    fast_sel;
    } intc_state_t;

    // Peripheral line copied into summary bit MIRROR_LSB + idx.
    function automatic int unsigned mirror_src(input int unsigned idx);
        case (idx)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            4:       return 19;
            5:       return 53;
            6:       return 54;
            7:       return 55;
            8:       return 56;
            9:       return 57;
            default: return 62;
        endcase
    endfunction

    // Byte offset within the window to register selector.
    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        case (off)
            8'h00:   return REG_SUMMARY;
            8'h04:   return REG_PEND_LO;
            8'h08:   return REG_PEND_HI;
            8'h0C:   return REG_FASTCTL;
            8'h10:   return REG_SET_LO;
            8'h14:   return REG_SET_HI;
            8'h18:   return REG_SET_LOC;
            8'h1C:   return REG_CLR_LO;
            8'h20:   return REG_CLR_HI;
            8'h24:   return REG_CLR_LOC;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/banked_intc_regs.sv
module banked_intc_regs
    import banked_intc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N_PERIPH-1:0] periph_i,
    input  logic [N_LOCAL-1:0]  local_i,
    input  logic                wr_i,
    input  reg_sel_e            sel_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output intc_state_t         state_o
);

    intc_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.lvl_p = periph_i;
        st_d.lvl_l = local_i;
        if (wr_i) begin
            case (sel_i)
                REG_FASTCTL: begin
                    st_d.fast_sel = wdata_i[SEL_W-1:0];
                    st_d.fast_en  = wdata_i[SEL_W];
                end
                REG_SET_LO:  st_d.en_p[HALF_W-1:0]        = st_q.en_p[HALF_W-1:0] | wdata_i;
                REG_SET_HI:  st_d.en_p[N_PERIPH-1:HALF_W] = st_q.en_p[N_PERIPH-1:HALF_W] | wdata_i;
                REG_SET_LOC: st_d.en_l                    = st_q.en_l | wdata_i[N_LOCAL-1:0];
                REG_CLR_LO:  st_d.en_p[HALF_W-1:0]        = st_q.en_p[HALF_W-1:0] & ~wdata_i;
                REG_CLR_HI:  st_d.en_p[N_PERIPH-1:HALF_W] = st_q.en_p[N_PERIPH-1:HALF_W] & ~wdata_i;
                REG_CLR_LOC: st_d.en_l                    = st_q.en_l & ~wdata_i[N_LOCAL-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/banked_intc_rdmux.sv
module banked_intc_rdmux
    import banked_intc_pkg::*;
(
    input  intc_state_t       state_i,
    input  logic              rd_i,
    input  reg_sel_e          sel_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [N_PERIPH-1:0] pend_p;
    logic [N_LOCAL-1:0]  pend_l;
    logic [N_MIRROR-1:0] mirror;
    logic [DATA_W-1:0]   summary;
    logic [DATA_W-1:0]   mux;

    assign pend_p = state_i.lvl_p & state_i.en_p;
    assign pend_l = state_i.lvl_l & state_i.en_l;

    for (genvar gi = 0; gi < N_MIRROR; gi++) begin : g_mirror
        localparam int unsigned SRC = mirror_src(gi);
        assign mirror[gi] = pend_p[SRC];
    end

    assign summary = {{(DATA_W - MIRROR_LSB - N_MIRROR){1'b0}},
                      mirror,
                      |pend_p[N_PERIPH-1:HALF_W],
                      |pend_p[HALF_W-1:0],
                      pend_l};

    always_comb begin
        case (sel_i)
            REG_SUMMARY: mux = summary;
            REG_PEND_LO: mux = pend_p[HALF_W-1:0];
            REG_PEND_HI: mux = pend_p[N_PERIPH-1:HALF_W];
            REG_FASTCTL: mux = {{(DATA_W-SEL_W-1){1'b0}}, state_i.fast_en, state_i.fast_sel};
            REG_SET_LO:  mux = state_i.en_p[HALF_W-1:0];
            REG_SET_HI:  mux = state_i.en_p[N_PERIPH-1:HALF_W];
            REG_SET_LOC: mux = {{(DATA_W-N_LOCAL){1'b0}}, state_i.en_l};
            REG_CLR_LO:  mux = ~state_i.en_p[HALF_W-1:0];
            REG_CLR_HI:  mux = ~state_i.en_p[N_PERIPH-1:HALF_W];
            REG_CLR_LOC: mux = ~{{(DATA_W-N_LOCAL){1'b0}}, state_i.en_l};
            default:     mux = '0;
        endcase
    end

    assign rdata_o = rd_i ? mux : '0;

endmodule

// File: rtl/banked_intc_out.sv
module banked_intc_out
    import banked_intc_pkg::*;
(
    input  intc_state_t state_i,
    output logic        irq_o,
    output logic        fiq_o
);

    logic pick_local;
    logic pick_periph;
    logic fast_lvl;

    assign irq_o = |(state_i.lvl_p & state_i.en_p) | |(state_i.lvl_l & state_i.en_l);

    assign pick_periph = !state_i.fast_sel[SEL_W-1];
    assign pick_local  = state_i.fast_sel[SEL_W-1] && (state_i.fast_sel[SEL_W-2:3] == '0);

    always_comb begin
        fast_lvl = 1'b0;
        if (pick_periph) begin
            fast_lvl = state_i.lvl_p[state_i.fast_sel[SEL_W-2:0]];
        end else if (pick_local) begin
            fast_lvl = state_i.lvl_l[state_i.fast_sel[2:0]];
        end
    end

    assign fiq_o = state_i.fast_en & fast_lvl;

endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import banked_intc_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [63:0]         periph_irq_i,
    input  logic [7:0]          local_irq_i,
    input  logic                bus_valid_i,
    input  logic                bus_write_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);

    logic        in_window;
    reg_sel_e    sel;
    intc_state_t state;

    if (ADDR_W > 8) begin : g_wide_addr
        assign in_window = (bus_addr_i[ADDR_W-1:8] == '0);
    end else begin : g_narrow_addr
        assign in_window = 1'b1;
    end

    assign sel = in_window ? decode_offset(8'(bus_addr_i)) : REG_NONE;

    banked_intc_regs u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .periph_i (periph_irq_i),
        .local_i  (local_irq_i),
        .wr_i     (bus_valid_i & bus_write_i),
        .sel_i    (sel),
        .wdata_i  (bus_wdata_i),
        .state_o  (state)
    );

    banked_intc_rdmux u_rdmux (
        .state_i (state),
        .rd_i    (bus_valid_i & ~bus_write_i),
        .sel_i   (sel),
        .rdata_o (bus_rdata_o)
    );

    banked_intc_out u_out (
        .state_i (state),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o)
    );

    logic [N_PERIPH-1:0] chk_en_p;
    logic [N_LOCAL-1:0]  chk_en_l;
    logic                chk_fast_en;
    logic [SEL_W-1:0]    chk_fast_sel;

    assign chk_en_p     = state.en_p;
    assign chk_en_l     = state.en_l;
    assign chk_fast_en  = state.fast_en;
    assign chk_fast_sel = state.fast_sel;

endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk #(
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [63:0]       periph_irq_i,
    input logic              bus_valid_i,
    input logic              bus_write_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_wdata_i,
    input logic [31:0]       bus_rdata_o,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [63:0]       en_p,
    input logic [7:0]        en_l,
    input logic              fast_en,
    input logic [6:0]        fast_sel
);

    logic wr_any;
    logic rd_any;
    logic mapped;

    assign wr_any = bus_valid_i && bus_write_i;
    assign rd_any = bus_valid_i && !bus_write_i;
    assign mapped = (bus_addr_i < ADDR_W'('h28)) && (bus_addr_i[1:0] == 2'b00);

    a_r2_set_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_any && bus_addr_i == ADDR_W'('h10))
        |=> (en_p[31:0] == ($past(en_p[31:0]) | $past(bus_wdata_i))));

    a_r3_clear_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_any && bus_addr_i == ADDR_W'('h20))
        |=> (en_p[63:32] == ($past(en_p[63:32]) & ~$past(bus_wdata_i))));

    a_r7_no_irq_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_p == '0 && en_l == '0) |-> !irq_o);

    a_r8_fast_tracks_periph: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fast_en && !fast_sel[6] && $past(rst_ni))
        |-> (fiq_o == (($past(periph_irq_i) >> fast_sel[5:0]) & 64'd1) != 64'd0));

    a_r9_fast_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fast_en |-> !fiq_o);

    a_r10_pending_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_any && bus_addr_i == ADDR_W'('h04))
        |=> ($stable(en_p) && $stable(en_l) && $stable(fast_en) && $stable(fast_sel)));

    a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_any && !mapped) |-> (bus_rdata_o == 32'd0));

endmodule

bind banked_intc banked_intc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .periph_irq_i (periph_irq_i),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o),
    .en_p         (chk_en_p),
    .en_l         (chk_en_l),
    .fast_en      (chk_fast_en),
    .fast_sel     (chk_fast_sel)
);

// File: tb/banked_intc_tb.sv
`timescale 1ns/1ps
module banked_intc_tb;

    localparam int unsigned ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [63:0]       periph = '0;
    logic [7:0]        locl = '0;
    logic              valid = 1'b0;
    logic              write = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;
    logic              fiq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    banked_intc #(.ADDR_W(ADDR_W)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .periph_irq_i (periph),
        .local_irq_i  (locl),
        .bus_valid_i  (valid),
        .bus_write_i  (write),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .irq_o        (irq),
        .fiq_o        (fiq)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Monitor: read data is compared mid-cycle against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && valid && !write) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected read act=%h exp=none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: addr %h act=%h exp=%h", t, addr, rdata, e);
                end
            end
        end
    end

    // Tasks start and end at one time unit past a rising edge.
    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        valid = 1'b1; write = 1'b0; addr = a;
        @(posedge clk); #1;
        valid = 1'b0;
    endtask

    task automatic chk_out(input logic ei, input logic ef, input string t);
        checks++;
        if (irq !== ei || fiq !== ef) begin
            fails++;
            $display("FAIL %s: irq/fiq act=%b%b exp=%b%b", t, irq, fiq, ei, ef);
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: act=timeout exp=completion");
        finish_run();
    end

    initial begin
        periph = '1;
        locl = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_out(1'b0, 1'b0, "R1 outputs after reset");
        rd(9'h10, 32'h0, "R1 enable low cleared");
        rd(9'h18, 32'h0, "R1 local enable cleared");
        rd(9'h0C, 32'h0, "R1 fast control cleared");

        periph = '0;
        locl = '0;
        idle();

        // R2 / R3: set and clear semantics
        wr(9'h10, 32'h0000_0481);
        rd(9'h10, 32'h0000_0481, "R2 set bits");
        wr(9'h10, 32'h0002_0000);
        rd(9'h10, 32'h0002_0481, "R2 zero bits keep");
        rd(9'h1C, 32'hFFFD_FB7E, "R3 clear reg reads inverse");
        wr(9'h1C, 32'h0000_0401);
        rd(9'h10, 32'h0002_0080, "R3 clear bits");

        // R4 / R7 / R11
        periph = 64'h0000_0000_0002_0080;
        idle();
        rd(9'h04, 32'h0002_0080, "R4 pending low");
        rd(9'h08, 32'h0, "R4 pending high masked");
        chk_out(1'b1, 1'b0, "R7 irq from enabled line");
        periph = 64'h0000_0000_0002_0000;
        rd(9'h04, 32'h0002_0080, "R11 old value in change cycle");
        rd(9'h04, 32'h0002_0000, "R11 new value one edge later");
        wr(9'h1C, 32'hFFFF_FFFF);
        chk_out(1'b0, 1'b0, "R7 irq low when masked");

        // R5 local bank
        locl = 8'h05;
        wr(9'h18, 32'h0000_0004);
        rd(9'h00, 32'h0000_0004, "R5 local bits");
        chk_out(1'b1, 1'b0, "R7 irq from local");
        rd(9'h24, 32'hFFFF_FFFB, "R3 local clear reads inverse");

        // R5 / R6 summary and mirrors
        periph = (64'd1 << 9) | (64'd1 << 40) | (64'd1 << 62);
        wr(9'h10, 32'hFFFF_FFFF);
        wr(9'h14, 32'hFFFF_FFFF);
        rd(9'h00, 32'h0010_0B04, "R6 mirrors 9 and 62 with R5 flags");
        wr(9'h20, 32'h4000_0000);
        rd(9'h00, 32'h0000_0B04, "R6 masked mirror drops, flag stays");
        rd(9'h14, 32'hBFFF_FFFF, "R2 high enable readback");
        periph = (64'd1 << 7) | (64'd1 << 57);
        idle();
        rd(9'h00, 32'h0008_0704, "R6 mirrors 7 and 57");

        // R10: writes to read-only and unmapped offsets
        wr(9'h00, 32'hFFFF_FFFF);
        wr(9'h04, 32'h0);
        wr(9'h08, 32'h0);
        wr(9'h28, 32'hFFFF_FFFF);
        wr(9'h1FC, 32'hFFFF_FFFF);
        wr(9'h11C, 32'hFFFF_FFFF);
        rd(9'h10, 32'hFFFF_FFFF, "R10 enable low untouched");
        rd(9'h14, 32'hBFFF_FFFF, "R10 enable high untouched");
        rd(9'h0C, 32'h0, "R10 fast control untouched");
        rd(9'h28, 32'h0, "R10 unmapped read zero");
        rd(9'h110, 32'h0, "R10 out of window read zero");

        // R8 / R9: fast request ignores masks
        wr(9'h1C, 32'hFFFF_FFFF);
        wr(9'h20, 32'hFFFF_FFFF);
        wr(9'h24, 32'h0000_00FF);
        chk_out(1'b0, 1'b0, "R7 all masked");
        wr(9'h0C, 32'hFFFF_FF00 | 32'h80 | 32'd57);
        rd(9'h0C, 32'h0000_00B9, "R8 control readback");
        chk_out(1'b0, 1'b1, "R8 fiq follows masked line 57");
        periph = (64'd1 << 7);
        idle();
        chk_out(1'b0, 1'b0, "R8 fiq drops with line 57");
        wr(9'h0C, 32'h80 | 32'd66);
        chk_out(1'b0, 1'b1, "R9 local line 2 selected");
        wr(9'h0C, 32'h80 | 32'd65);
        chk_out(1'b0, 1'b0, "R9 local line 1 low");
        locl = 8'hFF;
        wr(9'h0C, 32'h80 | 32'd72);
        chk_out(1'b0, 1'b0, "R9 select above range low");
        wr(9'h0C, 32'd66);
        chk_out(1'b0, 1'b0, "R9 disabled low");
        rd(9'h0C, 32'h0000_0042, "R8 disabled readback");

        idle();
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: act=%0d pending exp=0", exp_q.size());
        end
        finish_run();
    end

endmodule